// File: doc/BRIEF.md
# Table-Driven Machine Tool Supervisor

This block supervises a machine tool with a halt request and a set of event inputs. It drives three indicators: a waiting lamp, a bell and a halted light. All of its behaviour comes from a constant lookup table. The table is addressed by the live inputs together with one stored state bit. Each table word carries the three indicator values and the next value of the state bit. A clocked register holds the state bit and feeds it back into the address.

The state bit records a halt. Once the halt request is seen high at a clock edge, the stored bit sets and keeps the halted light on until reset, whatever the inputs do afterwards. While the controller is not halted, the waiting lamp lights when every input is quiet, and the bell rings when any event input is active. The indicators are combinational from the current address, so they respond within the same cycle.

The table contents are computed at elaboration by a package function, so no initialisation file is needed. The number of event inputs is a parameter, and the table depth follows from it (16 words for the default of two events).

Top module: `mtc_controller`

## Requirements
- R1: When halt_req is high at a rising clock edge with rst_n high, the stored halt bit is set at that edge and halted reads 1 in every later cycle.
- R2: Once the stored halt bit is set, it stays set under every combination of halt_req and evt_in until a reset.
- R3: While halt_req is high or the stored halt bit is set, halted is 1 and both lamp_wait and bell are 0.
- R4: While not halted and with halt_req and every evt_in bit at 0, lamp_wait is 1, and bell and halted are 0.
- R5: While not halted and with at least one evt_in bit at 1, bell is 1, and lamp_wait and halted are 0.
- R6: At every clock edge outside reset, exactly one of lamp_wait, bell and halted is 1. In particular, lamp_wait and bell are never 1 together.
- R7: Reset is synchronous and active low. A rising edge with rst_n low clears the stored halt bit, including after a halt, so that with quiet inputs lamp_wait reads 1.
- R8: The indicators follow a change of halt_req or evt_in within the same cycle, with no register on the path from input to indicator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request |
| evt_in | input | N_EVT (2) | Event inputs |
| lamp_wait | output | 1 | Waiting lamp, lit while idle |
| bell | output | 1 | Bell, sounds on any event |
| halted | output | 1 | Halted indicator |

## Verification
The hardest state to reach from the ports is a halt that has already been stored while halt_req has gone low again and events keep arriving. Only that combination separates the stored bit from the live request. The bench drives every three-step sequence of input vectors from reset. As a result, each halt is followed by each possible later vector, and a reset is then applied to a halted controller to show that it recovers.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef struct packed {
    logic lamp;
    logic bell;
    logic stop;
    logic nxt;
  } mtc_word_t;

  // Address layout: {halt_req, evt_in[n_evt-1:0], stored_state}
  function automatic mtc_word_t mtc_compose(input int unsigned addr, input int unsigned n_evt);
    mtc_word_t   w;
    logic        st;
    logic        hq;
    int unsigned ev;
    st = addr[0];
    ev = (addr >> 1) & ((32'd1 << n_evt) - 32'd1);
    hq = (addr >> (n_evt + 1)) & 32'd1;
    if (hq || st) begin
      w.lamp = 1'b0;
      w.bell = 1'b0;
      w.stop = 1'b1;
      w.nxt  = 1'b1;
    end else begin
      w.lamp = (ev == 0);
      w.bell = (ev != 0);
      w.stop = 1'b0;
      w.nxt  = 1'b0;
    end
    return w;
  endfunction

endpackage

// File: rtl/mtc_addr_pack.sv
module mtc_addr_pack #(
  parameter int N_EVT  = 2,
  localparam int ADDR_W = N_EVT + 2
) (
  input  logic              halt_req,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic              state_q,
  output logic [ADDR_W-1:0] addr
);
  assign addr = {halt_req, evt_in, state_q};
endmodule

// File: rtl/mtc_rom.sv
module mtc_rom
  import mtc_pkg::*;
#(
  parameter int N_EVT  = 2,
  localparam int ADDR_W = N_EVT + 2,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output mtc_word_t         word
);
  mtc_word_t tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam mtc_word_t CONTENT = mtc_compose(i, N_EVT);
    assign tbl[i] = CONTENT;
  end

  assign word = tbl[addr];
endmodule

// File: rtl/mtc_state_reg.sv
module mtc_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/mtc_controller.sv
module mtc_controller
  import mtc_pkg::*;
#(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic [N_EVT-1:0] evt_in,
  output logic             lamp_wait,
  output logic             bell,
  output logic             halted
);
  localparam int ADDR_W = N_EVT + 2;

  logic [ADDR_W-1:0] rom_addr;
  mtc_word_t         rom_word;
  logic              state_q;
  logic              any_event;
  logic              stop_cond;

  mtc_addr_pack #(.N_EVT(N_EVT)) u_addr (
    .halt_req (halt_req),
    .evt_in   (evt_in),
    .state_q  (state_q),
    .addr     (rom_addr)
  );

  mtc_rom #(.N_EVT(N_EVT)) u_rom (
    .addr (rom_addr),
    .word (rom_word)
  );

  mtc_state_reg u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rom_word.nxt),
    .q     (state_q)
  );

  assign lamp_wait = rom_word.lamp;
  assign bell      = rom_word.bell;
  assign halted    = rom_word.stop;

  // Named conditions observed by the assertions
  assign any_event = |evt_in;
  assign stop_cond = halt_req | state_q;

  assert_halt_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> state_q);
  assert_halt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q |=> state_q);
  assert_halt_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cond |-> (halted && !lamp_wait && !bell));
  assert_idle_lamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_cond && !any_event) |-> (lamp_wait && !bell && !halted));
  assert_event_bell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_cond && any_event) |-> (bell && !lamp_wait && !halted));
  assert_one_indicator_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lamp_wait, bell, halted}) == 1);
endmodule

// File: tb/mtc_controller_test.sv
module mtc_controller_test;
  localparam int N_EVT = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             halt_req = 1'b0;
  logic [N_EVT-1:0] evt_in = '0;
  logic             lamp_wait, bell, halted;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  bit  ref_halt = 0;

  always #4 clk = ~clk;

  mtc_controller #(.N_EVT(N_EVT)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .evt_in(evt_in),
    .lamp_wait(lamp_wait), .bell(bell), .halted(halted)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {lamp,bell,halted} actual=%b expected=%b", req, got, exp);
    end
  endtask

  // Expected indicators computed from the requirements
  task automatic check_now(input string extra);
    logic h, q;
    h = ref_halt | halt_req;
    q = (evt_in == '0);
    if (h)      check({"R3 ", extra}, {lamp_wait, bell, halted}, 3'b001);
    else if (q) check({"R4 ", extra}, {lamp_wait, bell, halted}, 3'b100);
    else        check({"R5 ", extra}, {lamp_wait, bell, halted}, 3'b010);
    check({"R6 ", extra}, 3'(lamp_wait & bell), 3'b000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; halt_req = 1'b0; evt_in = '0;
    @(posedge clk);
    ref_halt = 0;
    @(negedge clk);
    #1 check("R7 reset clears", {lamp_wait, bell, halted}, 3'b100);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic a, input logic [N_EVT-1:0] e, input string extra);
    @(negedge clk);
    halt_req = a; evt_in = e;
    #1 check_now(extra);   // R8: same-cycle response
    @(posedge clk);
    if (a) ref_halt = 1;
  endtask

  initial begin
    do_reset();
    // Exhaustive three-step sweeps from reset: R1 R2 R3 R4 R5 R6 R8
    for (int s0 = 0; s0 < 8; s0++) begin
      for (int s1 = 0; s1 < 8; s1++) begin
        for (int s2 = 0; s2 < 8; s2++) begin
          step(s0[2], s0[1:0], "step0");
          step(s1[2], s1[1:0], "step1");
          step(s2[2], s2[1:0], "step2");
          @(negedge clk);
          halt_req = 1'b0; evt_in = '0;
          #1 if (s0[2] | s1[2] | s2[2])
            check("R1 capture", {lamp_wait, bell, halted}, 3'b001);
          else
            check("R4 idle", {lamp_wait, bell, halted}, 3'b100);
          do_reset();
        end
      end
    end
    // Single-cycle halt pulse, then long activity: R1 R2
    step(1'b1, 2'b00, "pulse");
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      halt_req = 1'b0; evt_in = 2'(k);
      #1 check("R2 sticky", {lamp_wait, bell, halted}, 3'b001);
    end
    // Reset out of halted state: R7
    do_reset();
    @(negedge clk);
    #1 check("R7 after halt", {lamp_wait, bell, halted}, 3'b100);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule